// File: doc/BRIEF.md
# Programmable Watchdog Timer with Steering

This block supervises a processor by counting a 16 Hz time base from the last sign of life. Software sets one 8-bit configuration register that holds a five-bit multiplier, a two-bit resolution code and a steering bit. The timeout is the multiplier times the resolution. The countdown restarts on any transition of the external service pin, which passes through a two-flop synchronizer first. It also restarts on any write to the register.

When the timeout expires, the block sets a sticky watchdog flag. Reading the flags register clears that flag. With the steering bit clear, the expiry raises a level interrupt that stays up until software writes 00h. With the steering bit set, the expiry drives an active-low reset pulse of fixed length. In the same clock cycle the block clears its own configuration and emits a one-cycle request to clear the neighbouring frequency-test enable.

Top module: `wdog_steer`

## Requirements
- R1: The configuration byte holds the multiplier in bits 6..2 and the resolution code in bits 1..0, with bit 7 as the steering bit. The resolution codes are 00 = 1 tick, 01 = 4 ticks, 10 = 16 ticks and 11 = 64 ticks of the 16 Hz enable.
- R2: The timeout is the multiplier times the resolution, counted in time-base ticks from the last restart. The flag rises on the clock edge of the tick that completes that count; for example, 0x0E expires on the 48th tick.
- R3: With the steering bit at 0, an expiry raises `irq_o` and `wd_flag_o`. `irq_o` then stays high until 00h is written, and the reset output stays high.
- R4: With the steering bit at 1, an expiry pulls `rst_n_o` low for exactly RST_TICKS ticks; the default of 2 ticks is 125 ms, inside the 40 to 200 ms window. On the same edge `cfg_o` becomes 00h and `ft_clr_o` pulses for one cycle. `irq_o` is not raised.
- R5: A rising or a falling edge on `wdi_i` restarts the count. The edge takes effect three clock edges after the pin changes.
- R6: Any write to the register restarts the count, even when the value written is unchanged.
- R7: Writing 00h clears a pending interrupt and keeps the timer from expiring until a non-zero multiplier is written.
- R8: A multiplier of zero keeps the timer idle, whatever the resolution and steering bits hold.
- R9: A flags-read strobe clears `wd_flag_o`. An expiry in the same cycle as the strobe wins, and `irq_o` is unaffected by the read.
- R10: After reset, `cfg_o` is 00h, `irq_o` and `wd_flag_o` are low, `ft_clr_o` is low and `rst_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up and power-down) |
| tick_i | input | 1 | One-cycle enable at 16 Hz |
| wdi_i | input | 1 | Asynchronous watchdog service pin |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| flag_rd_i | input | 1 | Flags-register read strobe |
| cfg_o | output | 8 | Current register contents |
| irq_o | output | 1 | Interrupt, active high |
| rst_n_o | output | 1 | Reset pulse, active low |
| wd_flag_o | output | 1 | Sticky watchdog flag |
| ft_clr_o | output | 1 | One-cycle request to clear frequency-test enable |

## Verification
The properties assume that `tick_i` is a single-cycle pulse. They also assume that a register write and an expiry in the same cycle resolve in favour of the write, which cancels the expiry through the restart. The properties that tie the reset pulse to the tick take the tick as the only thing that ends the pulse. The bench drives every strobe for exactly one cycle on the falling clock edge and separates ticks by idle cycles. It changes `wdi_i` only between ticks and leaves three cycles for synchronization, so none of these assumptions is violated.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CFG_W  = 8;
    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    // widest timeout: 31 * 64 ticks
    localparam int MAX_TICKS = ((1 << MULT_W) - 1) * (1 << (2 * ((1 << RES_W) - 1)));
    localparam int CNT_W  = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_cfg_t;

    typedef logic [CNT_W-1:0] wd_cnt_t;

endpackage

// File: rtl/wd_sync_edge.sv
module wd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic edge_o
);
    // STAGES synchronizer flops plus one history flop
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/wd_limit.sv
module wd_limit
    import wdog_pkg::*;
(
    input  wd_cfg_t cfg_i,
    output wd_cnt_t limit_o,
    output logic    armed_o
);
    wd_cnt_t base;

    always_comb begin
        base    = wd_cnt_t'(cfg_i.mult);
        limit_o = base << (2 * cfg_i.res);
        armed_o = (cfg_i.mult != '0);
    end
endmodule

// File: rtl/wd_pulse.sv
module wd_pulse #(
    parameter int RST_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic tick_i,
    output logic low_o
);
    localparam int PW = $clog2(RST_TICKS + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i)
            st_d.left = PW'(RST_TICKS);
        else if (tick_i && st_q.left != '0)
            st_d.left = st_q.left - PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign low_o = (st_q.left != '0);
endmodule

// File: rtl/wd_core.sv
module wd_core
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             flag_rd_i,
    input  wd_cnt_t          limit_i,
    input  logic             armed_i,
    output wd_cfg_t          cfg_o,
    output logic             irq_o,
    output logic             flag_o,
    output logic             ftc_o,
    output logic             fire_o
);
    typedef struct packed {
        wd_cfg_t cfg;
        wd_cnt_t cnt;
        logic    irq;
        logic    flag;
        logic    ftc;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     fire;
    wd_cnt_t  cnt_inc;

    always_comb begin
        st_d     = st_q;
        st_d.ftc = 1'b0;
        fire     = 1'b0;
        cnt_inc  = st_q.cnt + wd_cnt_t'(1);

        if (restart_i) begin
            st_d.cnt = '0;
        end else if (tick_i && armed_i) begin
            if (cnt_inc == limit_i) begin
                fire     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end

        if (fire) begin
            st_d.flag = 1'b1;
            if (st_q.cfg.steer) begin
                st_d.cfg = '0;
                st_d.ftc = 1'b1;
            end else begin
                st_d.irq = 1'b1;
            end
        end

        if (cfg_wr_i) begin
            st_d.cfg = wd_cfg_t'(cfg_wdata_i);
            if (cfg_wdata_i == '0) st_d.irq = 1'b0;
        end

        if (flag_rd_i && !fire) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o  = st_q.cfg;
    assign irq_o  = st_q.irq;
    assign flag_o = st_q.flag;
    assign ftc_o  = st_q.ftc;
    assign fire_o = fire && st_q.cfg.steer;
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
    import wdog_pkg::*;
#(
    parameter int RST_TICKS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wdi_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             flag_rd_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic             irq_o,
    output logic             rst_n_o,
    output logic             wd_flag_o,
    output logic             ft_clr_o
);
    logic    wdi_edge;
    logic    restart;
    logic    armed;
    logic    fire_rst;
    logic    pulse_low;
    wd_cnt_t limit;
    wd_cfg_t cfg;

    wd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (wdi_i),
        .edge_o (wdi_edge)
    );

    assign restart = wdi_edge | cfg_wr_i;

    wd_limit u_limit (
        .cfg_i   (cfg),
        .limit_o (limit),
        .armed_o (armed)
    );

    wd_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .restart_i   (restart),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .flag_rd_i   (flag_rd_i),
        .limit_i     (limit),
        .armed_i     (armed),
        .cfg_o       (cfg),
        .irq_o       (irq_o),
        .flag_o      (wd_flag_o),
        .ftc_o       (ft_clr_o),
        .fire_o      (fire_rst)
    );

    wd_pulse #(.RST_TICKS(RST_TICKS)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire_rst),
        .tick_i (tick_i),
        .low_o  (pulse_low)
    );

    assign cfg_o   = cfg;
    assign rst_n_o = !pulse_low;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       cfg_wr_i,
    input logic [7:0] cfg_wdata_i,
    input logic       flag_rd_i,
    input logic [7:0] cfg_o,
    input logic       irq_o,
    input logic       rst_n_o,
    input logic       wd_flag_o,
    input logic       ft_clr_o
);
    a_r7_zero_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && cfg_wdata_i == 8'h00) |=> !irq_o);

    a_r3_irq_only_unsteered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (!$past(cfg_o[7]) && wd_flag_o));

    a_r4_pulse_needs_steer: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_n_o) |-> $past(cfg_o[7]));

    a_r4_pulse_clears_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_n_o) |-> (cfg_o == 8'h00 && ft_clr_o && wd_flag_o));

    a_r4_pulse_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_n_o && !tick_i) |=> !rst_n_o);

    a_r8_idle_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[6:2] == 5'd0 && !cfg_wr_i) |=> !$rose(wd_flag_o));

    a_r9_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd_i && !tick_i) |=> !wd_flag_o);
endmodule

bind wdog_steer wdog_steer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .flag_rd_i   (flag_rd_i),
    .cfg_o       (cfg_o),
    .irq_o       (irq_o),
    .rst_n_o     (rst_n_o),
    .wd_flag_o   (wd_flag_o),
    .ft_clr_o    (ft_clr_o)
);

// File: tb/wdog_steer_tb.sv
module wdog_steer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wdi_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [7:0] cfg_wdata_i = 8'h00;
    logic       flag_rd_i = 1'b0;
    logic [7:0] cfg_o;
    logic       irq_o, rst_n_o, wd_flag_o, ft_clr_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    wdog_steer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wdi_i(wdi_i),
        .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .flag_rd_i(flag_rd_i),
        .cfg_o(cfg_o), .irq_o(irq_o), .rst_n_o(rst_n_o),
        .wd_flag_o(wd_flag_o), .ft_clr_o(ft_clr_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk) begin cfg_wr_i = 1'b1; cfg_wdata_i = v; end
        @(negedge clk) cfg_wr_i = 1'b0;
    endtask

    task automatic rd_flag();
        @(negedge clk) flag_rd_i = 1'b1;
        @(negedge clk) flag_rd_i = 1'b0;
    endtask

    task automatic toggle_wdi();
        @(negedge clk) wdi_i = ~wdi_i;
        repeat (3) @(negedge clk);
    endtask

    task automatic clean();
        wr(8'h00);
        rd_flag();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 cfg", cfg_o, 0);
        chk("R10 irq", irq_o, 0);
        chk("R10 flag", wd_flag_o, 0);
        chk("R10 rst_n_o", rst_n_o, 1);
        chk("R10 ft_clr", ft_clr_o, 0);
    endtask

    // R2 R3: 0x0E -> multiplier 3, resolution 16 ticks -> 48 ticks
    task automatic t_example();
        clean();
        wr(8'h0E);
        ticks(47);
        chk("R2 flag before 48", wd_flag_o, 0);
        ticks(1);
        chk("R2 flag at 48", wd_flag_o, 1);
        chk("R3 irq at expiry", irq_o, 1);
        chk("R3 rst_n_o stays high", rst_n_o, 1);
        ticks(60);
        chk("R3 irq held", irq_o, 1);
    endtask

    // R1: every resolution code with two multipliers
    task automatic t_resolutions();
        for (int m = 1; m <= 2; m++) begin
            for (int r = 0; r < 4; r++) begin
                int lim;
                lim = m * (1 << (2 * r));
                clean();
                wr(8'((m << 2) | r));
                ticks(lim - 1);
                chk("R1 no early expiry", wd_flag_o, 0);
                ticks(1);
                chk("R1 expiry at m*res", wd_flag_o, 1);
            end
        end
    endtask

    // R5: both pin edges restart; 0x0C -> 3 ticks
    task automatic t_wdi();
        clean();
        wr(8'h0C);
        ticks(2);
        toggle_wdi();
        ticks(2);
        chk("R5 rising edge restarts", wd_flag_o, 0);
        toggle_wdi();
        ticks(2);
        chk("R5 falling edge restarts", wd_flag_o, 0);
        ticks(1);
        chk("R5 expiry after last edge", wd_flag_o, 1);
    endtask

    // R6: rewrite of the same value restarts
    task automatic t_write_restart();
        clean();
        wr(8'h0C);
        ticks(2);
        wr(8'h0C);
        ticks(2);
        chk("R6 write restarts", wd_flag_o, 0);
        ticks(1);
        chk("R6 expiry after write", wd_flag_o, 1);
    endtask

    // R9 then R7
    task automatic t_clear();
        clean();
        wr(8'h04);
        ticks(1);
        chk("R9 flag set", wd_flag_o, 1);
        rd_flag();
        chk("R9 read clears flag", wd_flag_o, 0);
        chk("R9 read leaves irq", irq_o, 1);
        wr(8'h00);
        chk("R7 zero write clears irq", irq_o, 0);
        ticks(100);
        chk("R7 disabled no flag", wd_flag_o, 0);
        chk("R7 disabled no irq", irq_o, 0);
    endtask

    // R8: multiplier zero with every other field set
    task automatic t_idle();
        clean();
        wr(8'h83);
        ticks(150);
        chk("R8 idle flag", wd_flag_o, 0);
        chk("R8 idle reset", rst_n_o, 1);
        chk("R8 cfg kept", cfg_o, 8'h83);
    endtask

    // R4: steering 1, 0x84 -> 1 tick, pulse of 2 ticks
    task automatic t_steer();
        clean();
        wr(8'h84);
        ticks(1);
        chk("R4 rst_n_o low", rst_n_o, 0);
        chk("R4 ft_clr pulse", ft_clr_o, 1);
        chk("R4 cfg cleared", cfg_o, 0);
        chk("R4 flag set", wd_flag_o, 1);
        chk("R4 no irq", irq_o, 0);
        @(negedge clk);
        chk("R4 ft_clr one cycle", ft_clr_o, 0);
        chk("R4 low between ticks", rst_n_o, 0);
        ticks(1);
        chk("R4 low after 1 tick", rst_n_o, 0);
        ticks(1);
        chk("R4 high after 2 ticks", rst_n_o, 1);
        ticks(20);
        chk("R4 no second pulse", rst_n_o, 1);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_resolutions();
        t_wdi();
        t_write_restart();
        t_clear();
        t_idle();
        t_steer();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule